// File: doc/BRIEF.md
# Outstanding-Operation Wait Tracker

This block counts long-latency operations that a compute unit has sent out but has not yet seen finish. There are three categories, and each has its own counter. The first category is vector memory loads. The second is exports to memory or to the global shared store. The third is local-share, global-shared and constant reads, including messages. When an operation is issued, the counter for its category goes up by one. When that operation finishes, a completion pulse for the category brings the counter back down.

A wait instruction presents one threshold per category. The tracker holds a stall request high as long as any counter is above its threshold. A category that the wait does not care about is given its all-ones threshold, so it can never block. The counters keep running while unrelated work proceeds. The stall is computed combinationally from the registered counts, so it drops in the cycle right after the last needed completion is counted. A counter that is full refuses further issues of its category through a ready signal. A completion that arrives when its counter is already zero sets a sticky error flag.

Top module: `opwait_tracker`

## Requirements
- R1: After a synchronous active-low reset, all three counts are zero, `wait_stall` is low, `cnt_error` is low and `iss_ready` is high for category codes 0, 1 and 2.
- R2: An accepted issue (`iss_valid` and `iss_ready` both high) increments exactly one counter, chosen by `iss_cat`: code 0 selects vector memory (`cnt_vm`), code 1 selects export (`cnt_ex`) and code 2 selects shared/constant/message (`cnt_lc`). The new value is visible after the next rising edge.
- R3: A pulse on `done_vm`, `done_ex` or `done_lc` decrements the matching non-zero counter by one at the next rising edge.
- R4: If an accepted issue and a completion of the same category arrive in the same cycle, that counter keeps its value.
- R5: While the counter of the category selected by `iss_cat` is all ones, `iss_ready` is low. An issue presented in that state is not counted, and the counter never wraps.
- R6: Category code 3 is reserved. For code 3, `iss_ready` is low and no counter changes.
- R7: `wait_stall` is high exactly when `wait_valid` is high and at least one count is strictly greater than its threshold (`wait_vm`, `wait_ex`, `wait_lc`). It falls in the same cycle that the count meeting its threshold appears.
- R8: An all-ones threshold never causes a stall, whatever the count of that category.
- R9: A completion that arrives while its counter is zero and no issue of the same category is accepted in that cycle leaves the counter at zero. It also sets `cnt_error`, which stays high until reset.
- R10: The counters are independent. Issues and completions of one category leave the other two counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An operation is being issued this cycle |
| iss_cat | input | 2 | Category of the issued operation (0 vector memory, 1 export, 2 shared/constant/message, 3 reserved) |
| iss_ready | output | 1 | The selected category can accept an issue |
| done_vm | input | 1 | One vector memory load completed |
| done_ex | input | 1 | One export completed |
| done_lc | input | 1 | One shared/constant read or message completed |
| wait_valid | input | 1 | A wait instruction is active |
| wait_vm | input | VM_W | Vector memory threshold |
| wait_ex | input | EX_W | Export threshold |
| wait_lc | input | LC_W | Shared/constant/message threshold |
| wait_stall | output | 1 | Hold the instruction stream |
| cnt_vm | output | VM_W | Outstanding vector memory loads |
| cnt_ex | output | EX_W | Outstanding exports |
| cnt_lc | output | LC_W | Outstanding shared/constant reads and messages |
| cnt_error | output | 1 | Sticky flag for a completion that arrived with no operation outstanding |

## Verification
The bench narrows the counters to VM_W=4, EX_W=3 and LC_W=2, in place of the default 6/3/4. With these widths, saturation of every category takes at most 15 issues. The full-counter backpressure, the no-wrap guarantee and the all-ones threshold case can therefore each be exercised directly in a short directed scenario. The export width is left at its default, so the zero-threshold export wait is checked at the width the block ships with.

// File: rtl/opwait_pkg.sv
// Package: shared category encoding for the wait tracker.
// Assumes a 2-bit category field on the issue port.
package opwait_pkg;
    typedef enum logic [1:0] {
        CAT_VMEM = 2'd0,
        CAT_EXP  = 2'd1,
        CAT_LSC  = 2'd2,
        CAT_RSVD = 2'd3
    } opcat_e;
endpackage

// File: rtl/opwait_counter.sv
// Module: one saturating up/down counter of outstanding operations.
// Assumes the caller never raises inc while full is high.
// A same-cycle inc and dec cancel each other. A dec at zero is reported, not applied.
module opwait_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         full,
    output logic         under
);
    // Count register: step up, step down or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && !dec)
            cnt <= cnt + 1'b1;
        else if (dec && !inc && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // Status flags derived from the current count.
    always_comb begin
        full  = &cnt;
        under = dec && !inc && (cnt == '0);
    end
endmodule

// File: rtl/opwait_gate.sv
// Module: wait comparator. It requests a stall while any count exceeds its threshold.
// Assumes the thresholds are held stable for as long as wait_valid is high.
module opwait_gate #(
    parameter int VM_W = 6,
    parameter int EX_W = 3,
    parameter int LC_W = 4
) (
    input  logic            wait_valid,
    input  logic [VM_W-1:0] cnt_vm,
    input  logic [EX_W-1:0] cnt_ex,
    input  logic [LC_W-1:0] cnt_lc,
    input  logic [VM_W-1:0] thr_vm,
    input  logic [EX_W-1:0] thr_ex,
    input  logic [LC_W-1:0] thr_lc,
    output logic            stall
);
    // Combinational stall decision.
    always_comb begin
        stall = wait_valid &&
                ((cnt_vm > thr_vm) || (cnt_ex > thr_ex) || (cnt_lc > thr_lc));
    end
endmodule

// File: rtl/opwait_tracker.sv
// Module: top of the outstanding-operation wait tracker.
// Assumes completions are single-cycle pulses, at most one per category per cycle.
// Assumes the issuer honours iss_ready.
module opwait_tracker #(
    parameter int VM_W = 6,
    parameter int EX_W = 3,
    parameter int LC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic [1:0]      iss_cat,
    output logic            iss_ready,
    input  logic            done_vm,
    input  logic            done_ex,
    input  logic            done_lc,
    input  logic            wait_valid,
    input  logic [VM_W-1:0] wait_vm,
    input  logic [EX_W-1:0] wait_ex,
    input  logic [LC_W-1:0] wait_lc,
    output logic            wait_stall,
    output logic [VM_W-1:0] cnt_vm,
    output logic [EX_W-1:0] cnt_ex,
    output logic [LC_W-1:0] cnt_lc,
    output logic            cnt_error
);
    import opwait_pkg::*;

    localparam int NCAT = 3;

    opcat_e          cat;
    logic [NCAT-1:0] full_v;
    logic [NCAT-1:0] inc_v;
    logic [NCAT-1:0] under_v;

    // Decode the category and gate the issue with backpressure.
    always_comb begin
        cat = opcat_e'(iss_cat);
        unique case (cat)
            CAT_VMEM: iss_ready = !full_v[0];
            CAT_EXP:  iss_ready = !full_v[1];
            CAT_LSC:  iss_ready = !full_v[2];
            default:  iss_ready = 1'b0;
        endcase
        for (int i = 0; i < NCAT; i++)
            inc_v[i] = iss_valid && iss_ready && (iss_cat == 2'(i));
    end

    opwait_counter #(.W(VM_W)) u_cnt_vm (
        .clk(clk), .rst_n(rst_n), .inc(inc_v[0]), .dec(done_vm),
        .cnt(cnt_vm), .full(full_v[0]), .under(under_v[0])
    );
    opwait_counter #(.W(EX_W)) u_cnt_ex (
        .clk(clk), .rst_n(rst_n), .inc(inc_v[1]), .dec(done_ex),
        .cnt(cnt_ex), .full(full_v[1]), .under(under_v[1])
    );
    opwait_counter #(.W(LC_W)) u_cnt_lc (
        .clk(clk), .rst_n(rst_n), .inc(inc_v[2]), .dec(done_lc),
        .cnt(cnt_lc), .full(full_v[2]), .under(under_v[2])
    );

    opwait_gate #(.VM_W(VM_W), .EX_W(EX_W), .LC_W(LC_W)) u_gate (
        .wait_valid(wait_valid),
        .cnt_vm(cnt_vm), .cnt_ex(cnt_ex), .cnt_lc(cnt_lc),
        .thr_vm(wait_vm), .thr_ex(wait_ex), .thr_lc(wait_lc),
        .stall(wait_stall)
    );

    // Sticky underflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_error <= 1'b0;
        else if (|under_v)
            cnt_error <= 1'b1;
    end
endmodule

// File: rtl/opwait_tracker_chk.sv
// Module: property checker for opwait_tracker, attached with bind.
// Assumes the same parameter values as the instance it observes.
module opwait_tracker_chk #(
    parameter int VM_W = 6,
    parameter int EX_W = 3,
    parameter int LC_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iss_valid,
    input logic [1:0]      iss_cat,
    input logic            iss_ready,
    input logic            done_vm,
    input logic            done_ex,
    input logic            done_lc,
    input logic            wait_valid,
    input logic [VM_W-1:0] wait_vm,
    input logic [EX_W-1:0] wait_ex,
    input logic [LC_W-1:0] wait_lc,
    input logic            wait_stall,
    input logic [VM_W-1:0] cnt_vm,
    input logic [EX_W-1:0] cnt_ex,
    input logic [LC_W-1:0] cnt_lc,
    input logic            cnt_error
);
    localparam logic [VM_W-1:0] VM_MAX = {VM_W{1'b1}};
    localparam logic [EX_W-1:0] EX_MAX = {EX_W{1'b1}};
    localparam logic [LC_W-1:0] LC_MAX = {LC_W{1'b1}};

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_vm == VM_MAX) |=> (cnt_vm != '0)); // R5
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_cat == 2'd1 && cnt_ex == EX_MAX) |-> !iss_ready); // R5
    AST_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_cat == 2'd3) |-> !iss_ready); // R6
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_cat == 2'd0 && done_vm) |=> $stable(cnt_vm)); // R4
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(iss_valid && iss_cat == 2'd2) && !done_lc) |=> $stable(cnt_lc)); // R10
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_valid |-> !wait_stall); // R7
    AST_MAX_THR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_vm == VM_MAX && wait_ex == EX_MAX && wait_lc == LC_MAX) |-> !wait_stall); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_error |=> cnt_error); // R9
endmodule

bind opwait_tracker opwait_tracker_chk #(.VM_W(VM_W), .EX_W(EX_W), .LC_W(LC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cat(iss_cat),
    .iss_ready(iss_ready), .done_vm(done_vm), .done_ex(done_ex), .done_lc(done_lc),
    .wait_valid(wait_valid), .wait_vm(wait_vm), .wait_ex(wait_ex), .wait_lc(wait_lc),
    .wait_stall(wait_stall), .cnt_vm(cnt_vm), .cnt_ex(cnt_ex), .cnt_lc(cnt_lc),
    .cnt_error(cnt_error)
);

// File: tb/opwait_tracker_bench.sv
module opwait_tracker_bench;
    localparam int VM_W = 4;
    localparam int EX_W = 3;
    localparam int LC_W = 2;
    localparam int VM_MAX = (1 << VM_W) - 1;
    localparam int EX_MAX = (1 << EX_W) - 1;
    localparam int LC_MAX = (1 << LC_W) - 1;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            iss_valid;
    logic [1:0]      iss_cat;
    logic            iss_ready;
    logic            done_vm, done_ex, done_lc;
    logic            wait_valid;
    logic [VM_W-1:0] wait_vm;
    logic [EX_W-1:0] wait_ex;
    logic [LC_W-1:0] wait_lc;
    logic            wait_stall;
    logic [VM_W-1:0] cnt_vm;
    logic [EX_W-1:0] cnt_ex;
    logic [LC_W-1:0] cnt_lc;
    logic            cnt_error;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    opwait_tracker #(.VM_W(VM_W), .EX_W(EX_W), .LC_W(LC_W)) u_opwait_tracker (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cat(iss_cat),
        .iss_ready(iss_ready), .done_vm(done_vm), .done_ex(done_ex), .done_lc(done_lc),
        .wait_valid(wait_valid), .wait_vm(wait_vm), .wait_ex(wait_ex), .wait_lc(wait_lc),
        .wait_stall(wait_stall), .cnt_vm(cnt_vm), .cnt_ex(cnt_ex), .cnt_lc(cnt_lc),
        .cnt_error(cnt_error)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        iss_valid = 0; iss_cat = 0;
        done_vm = 0; done_ex = 0; done_lc = 0;
        wait_valid = 0;
        wait_vm = '1; wait_ex = '1; wait_lc = '1;
    endtask

    // Inputs change at the falling edge, the rising edge updates, the next falling edge samples.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        step();
        rst_n = 1;
        #1;
    endtask

    task automatic issue(input int c, input int n);
        for (int i = 0; i < n; i++) begin
            iss_valid = 1; iss_cat = 2'(c);
            step();
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cnt_vm", int'(cnt_vm), 0);
        chk("R1 cnt_ex", int'(cnt_ex), 0);
        chk("R1 cnt_lc", int'(cnt_lc), 0);
        chk("R1 err", int'(cnt_error), 0);
        chk("R1 stall", int'(wait_stall), 0);
        for (int c = 0; c < 3; c++) begin
            iss_cat = 2'(c); #1;
            chk("R1 ready", int'(iss_ready), 1);
        end
    endtask

    task automatic t_issue_complete();
        do_reset();
        issue(0, 3);
        chk("R2 vm after 3", int'(cnt_vm), 3);
        chk("R10 ex untouched", int'(cnt_ex), 0);
        chk("R10 lc untouched", int'(cnt_lc), 0);
        issue(1, 2);
        issue(2, 1);
        chk("R2 ex after 2", int'(cnt_ex), 2);
        chk("R2 lc after 1", int'(cnt_lc), 1);
        chk("R10 vm untouched", int'(cnt_vm), 3);
        done_vm = 1; step();
        chk("R3 vm down", int'(cnt_vm), 2);
        chk("R10 ex kept", int'(cnt_ex), 2);
        done_ex = 1; done_lc = 1; step();
        chk("R3 ex down", int'(cnt_ex), 1);
        chk("R3 lc down", int'(cnt_lc), 0);
    endtask

    task automatic t_pair();
        do_reset();
        issue(0, 2);
        iss_valid = 1; iss_cat = 0; done_vm = 1; step();
        chk("R4 vm pair hold", int'(cnt_vm), 2);
        issue(1, 1);
        iss_valid = 1; iss_cat = 1; done_ex = 1; step();
        chk("R4 ex pair hold", int'(cnt_ex), 1);
    endtask

    task automatic t_wait();
        do_reset();
        issue(1, 2);
        issue(0, 1);
        wait_valid = 1; wait_vm = '1; wait_ex = 0; wait_lc = '1; #1;
        chk("R7 stall export outstanding", int'(wait_stall), 1);
        done_ex = 1; step();
        wait_valid = 1; wait_ex = 0; #1;
        chk("R7 still stalled at 1", int'(wait_stall), 1);
        done_ex = 1; step();
        wait_valid = 1; wait_ex = 0; #1;
        chk("R7 released at 0", int'(wait_stall), 0);
        wait_vm = 0; #1;
        chk("R7 vm above thr", int'(wait_stall), 1);
        wait_vm = 1; #1;
        chk("R7 vm equal thr", int'(wait_stall), 0);
        wait_valid = 0; wait_vm = 0; #1;
        chk("R7 no wait no stall", int'(wait_stall), 0);
    endtask

    task automatic t_saturate();
        do_reset();
        issue(0, VM_MAX);
        chk("R5 vm full", int'(cnt_vm), VM_MAX);
        iss_cat = 0; #1;
        chk("R5 ready low", int'(iss_ready), 0);
        iss_valid = 1; iss_cat = 0; step();
        chk("R5 no wrap", int'(cnt_vm), VM_MAX);
        wait_valid = 1; #1;
        chk("R8 max thr no stall", int'(wait_stall), 0);
        issue(2, LC_MAX + 2);
        chk("R5 lc capped", int'(cnt_lc), LC_MAX);
        issue(1, EX_MAX);
        iss_cat = 1; #1;
        chk("R5 ex ready low", int'(iss_ready), 0);
        iss_cat = 2; #1;
        chk("R5 lc ready low", int'(iss_ready), 0);
    endtask

    task automatic t_reserved();
        do_reset();
        issue(0, 1);
        iss_cat = 3; #1;
        chk("R6 ready low", int'(iss_ready), 0);
        issue(3, 2);
        chk("R6 vm", int'(cnt_vm), 1);
        chk("R6 ex", int'(cnt_ex), 0);
        chk("R6 lc", int'(cnt_lc), 0);
    endtask

    task automatic t_underflow();
        do_reset();
        done_ex = 1; step();
        chk("R9 cnt stays 0", int'(cnt_ex), 0);
        chk("R9 err set", int'(cnt_error), 1);
        step(); step();
        chk("R9 err sticky", int'(cnt_error), 1);
        do_reset();
        iss_valid = 1; iss_cat = 2; done_lc = 1; step();
        chk("R9 paired no err", int'(cnt_error), 0);
        chk("R9 paired cnt", int'(cnt_lc), 0);
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        t_reset();
        t_issue_complete();
        t_pair();
        t_wait();
        t_saturate();
        t_reserved();
        t_underflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule